// File: doc/BRIEF.md
# SPI Serial Clock Generator

This block makes the serial clock of an SPI master out of a fast main clock. Two dividers run in series. A power-of-two prescaler emits one tick every `2 << div_sel` main-clock cycles. An even divider then counts `baud + 1` of those ticks per half period of the serial clock. A polarity input sets the level the serial clock rests at while nothing is being shifted.

Along with the clock, the block drives a one-cycle strobe when the clock leaves its idle level (the leading edge) and another when it returns to idle (the trailing edge). A data shifter uses these two strobes to decide when to sample and when to launch. Divider and polarity settings are captured only while `en` is low, so software programs them with the block disabled. It then raises `en` and waits for `ready` before starting a transfer.

Top module: `sclk_gen`

## Requirements
- R1: While `rst` is high, `lead_stb`, `trail_stb` and `ready` are 0 and `sclk` equals `cpol` one cycle later.
- R2: While enabled, every half period of `sclk` lasts exactly `(2 << div_sel) * (B + 1)` main-clock cycles, where B is the captured baud value after clamping. High and low halves are equal (50% duty).
- R3: The first `sclk` edge after `en` rises comes one full half period after the first rising `clk` edge that samples `en` high, never earlier.
- R4: A `baud` value below 4 behaves as 4, and a value above 63 behaves as 63. The fastest clock is therefore the main clock divided by 20 and the slowest is the main clock divided by 2048.
- R5: `lead_stb` is high for exactly one cycle, in the same cycle that `sclk` leaves the idle level. `trail_stb` is high for exactly one cycle, in the same cycle that `sclk` returns to idle. The two are never high together.
- R6: While `en` is low, `sclk` holds the idle level (equal to `cpol`, registered one cycle later) and both strobes stay low.
- R7: `div_sel`, `baud` and `cpol` are captured on every cycle in which `en` is low. Changes made while `en` is high do not alter the running clock.
- R8: `ready` rises two `clk` edges after the first edge that samples `en` high. It is 0 in any cycle in which `en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; settings are captured while low |
| div_sel | input | 2 | Prescale select, tick period is 2 << div_sel cycles |
| baud | input | 6 | Even divider field, clamped to 4..63 |
| cpol | input | 1 | Idle level of the serial clock |
| sclk | output | 1 | Serial clock |
| lead_stb | output | 1 | One-cycle pulse as sclk leaves idle |
| trail_stb | output | 1 | One-cycle pulse as sclk returns to idle |
| ready | output | 1 | Clock running with settled settings |

## Verification
The bench builds the block with its default parameters: a 2-bit prescale select, a 6-bit baud field and a legal range of 4 to 63. With these values the clamp at the low end is reachable, and so is the slowest setting, whose half period is 1024 cycles. The upper clamp cannot be reached through a 6-bit field. The bench draws settings at random and adds directed runs at both speed extremes and at both polarities. In some runs it disturbs the settings while the clock is running, to show that they are ignored.

// File: rtl/sclk_gen_pkg.sv
package sclk_gen_pkg;
  typedef enum logic [1:0] {
    EDGE_NONE  = 2'd0,
    EDGE_LEAD  = 2'd1,
    EDGE_TRAIL = 2'd2
  } edge_kind_e;
endpackage

// File: rtl/sclk_cfg_hold.sv
module sclk_cfg_hold #(
  parameter int DIV_W   = 2,
  parameter int BAUD_W  = 6,
  parameter int BRG_MIN = 4,
  parameter int BRG_MAX = 63
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [DIV_W-1:0]  div_in,
  input  logic [BAUD_W-1:0] baud_in,
  input  logic              pol_in,
  output logic [DIV_W-1:0]  div_q,
  output logic [BAUD_W-1:0] brg_q,
  output logic              pol_q
);
  localparam int FIELD_MAX = (1 << BAUD_W) - 1;

  logic [BAUD_W-1:0] lo_clamped;
  logic [BAUD_W-1:0] brg_clamped;

  assign lo_clamped = (baud_in < BAUD_W'(BRG_MIN)) ? BAUD_W'(BRG_MIN) : baud_in;

  generate
    if (BRG_MAX < FIELD_MAX) begin : g_hi_clamp
      assign brg_clamped = (lo_clamped > BAUD_W'(BRG_MAX)) ? BAUD_W'(BRG_MAX) : lo_clamped;
    end else begin : g_no_hi_clamp
      assign brg_clamped = lo_clamped;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= '0;
      brg_q <= BAUD_W'(BRG_MIN);
      pol_q <= 1'b0;
    end else if (!en) begin
      div_q <= div_in;
      brg_q <= brg_clamped;
      pol_q <= pol_in;
    end
  end
endmodule

// File: rtl/sclk_prescale.sv
module sclk_prescale #(
  parameter int DIV_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [DIV_W-1:0] div_sel,
  output logic             tick
);
  localparam int PRE_W = (1 << DIV_W) + 1;

  logic [PRE_W-1:0] cnt;
  logic [PRE_W-1:0] last;

  assign last = (PRE_W'(1) << ({1'b0, div_sel} + 1'b1)) - PRE_W'(1);
  assign tick = en && (cnt == last);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + PRE_W'(1);
    end
  end
endmodule

// File: rtl/sclk_halfdiv.sv
module sclk_halfdiv
  import sclk_gen_pkg::*;
#(
  parameter int BAUD_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              tick,
  input  logic [BAUD_W-1:0] brg,
  input  logic              pol_run,
  input  logic              pol_idle,
  output logic              sclk,
  output logic              lead_stb,
  output logic              trail_stb
);
  logic [BAUD_W-1:0] cnt;
  logic              wrap;
  edge_kind_e        kind;

  assign wrap = tick && (cnt == brg);

  always_comb begin
    kind = EDGE_NONE;
    if (wrap) begin
      kind = (sclk == pol_run) ? EDGE_LEAD : EDGE_TRAIL;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt       <= '0;
      sclk      <= pol_idle;
      lead_stb  <= 1'b0;
      trail_stb <= 1'b0;
    end else begin
      lead_stb  <= (kind == EDGE_LEAD);
      trail_stb <= (kind == EDGE_TRAIL);
      if (wrap) begin
        cnt  <= '0;
        sclk <= ~sclk;
      end else if (tick) begin
        cnt <= cnt + BAUD_W'(1);
      end
    end
  end
endmodule

// File: rtl/sclk_ready.sv
module sclk_ready (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic ready
);
  logic stage1;
  logic stage2;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= 1'b0;
      stage2 <= 1'b0;
    end else begin
      stage1 <= en;
      stage2 <= stage1 && en;
    end
  end

  assign ready = stage2 && en;
endmodule

// File: rtl/sclk_gen.sv
module sclk_gen #(
  parameter int DIV_W   = 2,
  parameter int BAUD_W  = 6,
  parameter int BRG_MIN = 4,
  parameter int BRG_MAX = 63
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [DIV_W-1:0]  div_sel,
  input  logic [BAUD_W-1:0] baud,
  input  logic              cpol,
  output logic              sclk,
  output logic              lead_stb,
  output logic              trail_stb,
  output logic              ready
);
  logic [DIV_W-1:0]  div_q;
  logic [BAUD_W-1:0] brg_q;
  logic              pol_q;
  logic              tick;

  sclk_cfg_hold #(
    .DIV_W(DIV_W), .BAUD_W(BAUD_W), .BRG_MIN(BRG_MIN), .BRG_MAX(BRG_MAX)
  ) u_cfg (
    .clk(clk), .rst(rst), .en(en),
    .div_in(div_sel), .baud_in(baud), .pol_in(cpol),
    .div_q(div_q), .brg_q(brg_q), .pol_q(pol_q)
  );

  sclk_prescale #(.DIV_W(DIV_W)) u_pre (
    .clk(clk), .rst(rst), .en(en), .div_sel(div_q), .tick(tick)
  );

  sclk_halfdiv #(.BAUD_W(BAUD_W)) u_half (
    .clk(clk), .rst(rst), .en(en), .tick(tick), .brg(brg_q),
    .pol_run(pol_q), .pol_idle(cpol),
    .sclk(sclk), .lead_stb(lead_stb), .trail_stb(trail_stb)
  );

  sclk_ready u_rdy (
    .clk(clk), .rst(rst), .en(en), .ready(ready)
  );
endmodule

// File: rtl/sclk_gen_chk.sv
module sclk_gen_chk #(
  parameter int BRG_MIN = 4
) (
  input logic clk,
  input logic rst,
  input logic en,
  input logic cpol,
  input logic sclk,
  input logic lead_stb,
  input logic trail_stb,
  input logic ready
);
  localparam int MIN_HALF = 2 * (BRG_MIN + 1);

  int unsigned gap;

  always_ff @(posedge clk) begin
    if (rst || !en || lead_stb || trail_stb) begin
      gap <= 1;
    end else if (gap < 32'hFFFF_0000) begin
      gap <= gap + 1;
    end
  end

  a_r6_idle_level: assert property (@(posedge clk) disable iff (rst)
    !en |=> (sclk == $past(cpol)));

  a_r6_quiet_strobes: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!lead_stb && !trail_stb));

  a_r5_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(lead_stb && trail_stb));

  a_r5_lead_moves: assert property (@(posedge clk) disable iff (rst)
    lead_stb |-> (sclk != $past(sclk)));

  a_r5_trail_moves: assert property (@(posedge clk) disable iff (rst)
    trail_stb |-> (sclk != $past(sclk)));

  a_r5_edge_marked: assert property (@(posedge clk) disable iff (rst)
    ($past(en) && (sclk != $past(sclk))) |-> (lead_stb || trail_stb));

  a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
    (lead_stb || trail_stb) |=> (!lead_stb && !trail_stb));

  a_r8_ready_needs_en: assert property (@(posedge clk) disable iff (rst)
    ready |-> (en && $past(en)));

  a_r2_min_half: assert property (@(posedge clk) disable iff (rst)
    (lead_stb || trail_stb) |-> (gap >= MIN_HALF));
endmodule

bind sclk_gen sclk_gen_chk #(.BRG_MIN(BRG_MIN)) u_chk (
  .clk(clk), .rst(rst), .en(en), .cpol(cpol), .sclk(sclk),
  .lead_stb(lead_stb), .trail_stb(trail_stb), .ready(ready)
);

// File: tb/tb_sclk_gen.sv
module tb_sclk_gen;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b0;
  logic [1:0] div_sel = 2'd0;
  logic [5:0] baud = 6'd4;
  logic       cpol = 1'b0;
  logic       sclk, lead_stb, trail_stb, ready;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  sclk_gen dut (
    .clk(clk), .rst(rst), .en(en), .div_sel(div_sel), .baud(baud),
    .cpol(cpol), .sclk(sclk), .lead_stb(lead_stb), .trail_stb(trail_stb),
    .ready(ready)
  );

  function automatic int clamp_brg(input int b);
    if (b < 4) return 4;
    if (b > 63) return 63;
    return b;
  endfunction

  function automatic int half_len(input int d, input int b);
    return (2 << d) * (clamp_brg(b) + 1);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_case(input int d, input int b, input bit pol, input bit disturb);
    int h, k, last, nedges;
    bit level, steady;
    en = 1'b0; div_sel = 2'(d); baud = 6'(b); cpol = pol;
    repeat (3) @(negedge clk);
    check(sclk == pol, "R6 idle level", sclk, pol);
    check(!lead_stb && !trail_stb, "R6 strobes low", {lead_stb, trail_stb}, 0);
    h = half_len(d, b);
    en = 1'b1;
    k = 0; last = 0; nedges = 0; level = pol; steady = 1'b1;
    while (nedges < 4) begin
      @(posedge clk);
      @(negedge clk);
      k++;
      if (k == 1) check(ready == 1'b0, "R8 ready early", ready, 0);
      if (k == 2) check(ready == 1'b1, "R8 ready up", ready, 1);
      if (disturb && k == 3) begin
        div_sel = 2'(d ^ 3);
        baud = 6'(b ^ 6'h2A);
        cpol = ~pol;
      end
      if (lead_stb || trail_stb) begin
        if (nedges == 0) check(k == h, "R3 first edge", k, h);
        else if (disturb) check(k - last == h, "R7 period kept", k - last, h);
        else check(k - last == h, "R2 half period", k - last, h);
        check(lead_stb == (level == pol), "R5 strobe kind", lead_stb, level == pol);
        check(sclk == !level, "R5 sclk toggled", sclk, !level);
        level = !level;
        last = k;
        nedges++;
      end else if (sclk != level) begin
        steady = 1'b0;
      end
    end
    check(steady, "R2 no stray edge", steady, 1);
    @(negedge clk);
    en = 1'b0;
    #1;
    check(ready == 1'b0, "R8 ready drop", ready, 0);
    cpol = pol;
    @(posedge clk);
    @(negedge clk);
    check(sclk == pol, "R6 back to idle", sclk, pol);
    check(!lead_stb && !trail_stb, "R6 no strobe off", {lead_stb, trail_stb}, 0);
  endtask

  initial begin
    while (1) begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000) begin
        errors++;
        $display("FAIL watchdog actual=%0d expected=<190000", cycles);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    cpol = 1'b1;
    repeat (4) @(negedge clk);
    check(sclk == 1'b1, "R1 reset sclk", sclk, 1);
    check(!lead_stb && !trail_stb, "R1 reset strobes", {lead_stb, trail_stb}, 0);
    check(ready == 1'b0, "R1 reset ready", ready, 0);
    rst = 1'b0;
    cpol = 1'b0;
    repeat (2) @(negedge clk);

    run_case(0, 0, 1'b0, 1'b0);   // R4 clamp, fastest
    run_case(0, 3, 1'b1, 1'b0);   // R4 clamp just below limit
    run_case(0, 4, 1'b0, 1'b0);   // R2 smallest legal
    run_case(3, 63, 1'b1, 1'b0);  // R2 slowest
    run_case(1, 10, 1'b0, 1'b1);  // R7 disturbed run
    run_case(2, 1, 1'b1, 1'b1);   // R4 with R7

    for (int i = 0; i < 8; i++) begin
      run_case(int'($urandom % 4), int'($urandom % 64), 1'($urandom % 2), 1'($urandom % 2));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule